// File: doc/BRIEF.md
# Outstanding Request Occupancy Counter

This block watches the requests that sit between issue to a memory controller and the return of their data. An allocate pulse marks a new request in flight and a return pulse marks one that has completed. From these pulses it keeps a live count of pending requests. Three 48-bit accumulators are updated in every counting cycle:
- an occupancy sum, which adds the number of pending requests each cycle,
- a busy-cycle count, for cycles with at least one request pending,
- a saturated-cycle count, for cycles in which the pending count is at or above a programmable threshold.

Cycles counted as saturated point to a shortage of memory bandwidth. Software finds the cycles limited by latency by subtracting the saturated count from the busy count. Dividing the occupancy sum by the busy count gives the mean depth of the queue.

A small word-addressed register port handles configuration and readout. A two-state control machine gates counting. In RUN the accumulators advance. In FROZEN they hold their values while the live occupancy keeps tracking requests. A write to the control word with the freeze bit set takes RUN to FROZEN. A write with the freeze bit clear takes FROZEN back to RUN. No other event changes the state. A clear command zeroes all three accumulators in either state.

Top module: `ort_top`

## Requirements
- R1: After reset the occupancy is 0, all three accumulators are 0, the error flag is 0, the state is RUN and the threshold reads 28, which is 70% of the default maximum of 40 requests.
- R2: An allocate pulse alone raises the occupancy by one and a return pulse alone lowers it by one. Both pulses in the same cycle leave it unchanged. The occupancy reads at control word (address 0) bits [13:8].
- R3: A return pulse alone while the occupancy is 0 is ignored, and so is an allocate pulse alone while the occupancy is at the maximum (40). Either case sets a sticky error flag at control bit 1. Writing 1 to control bit 2 clears the flag.
- R4: In each counting cycle the occupancy sum adds the occupancy held during that cycle, that is, the value before that cycle's allocate or return takes effect.
- R5: The busy counter adds one in each counting cycle whose occupancy is at least 1.
- R6: The saturated counter adds one in each counting cycle whose occupancy is greater than or equal to the threshold. The threshold is written and read at address 1, bits [5:0].
- R7: Writing control bit 0 = 1 moves the block to FROZEN. Control bit 0 reads back as 1 in FROZEN. In FROZEN none of the accumulators changes, but the occupancy still tracks requests. Writing bit 0 = 0 returns the block to RUN. The cycle in which the write is presented still counts under the old state.
- R8: Writing control bit 1 = 1 sets all three accumulators to 0 at that clock edge, which overrides that cycle's accumulation.
- R9: Each accumulator is 48 bits wide. Its low 32 bits read at the even address and its high 16 bits read at the odd address above it: the sum at 2/3, busy at 4/5 and saturated at 6/7.
- R10: The read data follows the address in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_alloc_i | input | 1 | One request entered the controller |
| req_ret_i | input | 1 | One request returned its data |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |

## Verification
The assertions check the following on every cycle:
- the occupancy never rises above the maximum,
- an illegal pulse always raises the error flag,
- a frozen accumulator never moves,
- a clear always yields zero,
- the control state changes only on a control write.

Only the bench scenarios can show that the three accumulators hold the right totals over runs of mixed allocate and return traffic. The same holds for whether the boundary cycles of freeze, clear and threshold changes are counted or skipped.

// File: rtl/ort_pkg.sv
package ort_pkg;
    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_THR     = 3'd1,
        A_SUM_LO  = 3'd2,
        A_SUM_HI  = 3'd3,
        A_BUSY_LO = 3'd4,
        A_BUSY_HI = 3'd5,
        A_SAT_LO  = 3'd6,
        A_SAT_HI  = 3'd7
    } ort_addr_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FROZEN = 1'b1
    } ort_state_e;

    localparam int CTL_FREEZE_BIT = 0;
    localparam int CTL_CLR_BIT    = 1;
    localparam int CTL_ERRCLR_BIT = 2;
    localparam int CTL_OCC_LSB    = 8;
endpackage

// File: rtl/ort_occ_tracker.sv
module ort_occ_tracker #(
    parameter int MAX_REQ = 40,
    parameter int OCC_W   = $clog2(MAX_REQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             ret_i,
    input  logic             err_clr_i,
    output logic [OCC_W-1:0] occ_o,
    output logic             err_o
);
    localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(MAX_REQ);

    logic at_max, at_zero, bad_alloc, bad_ret;

    assign at_max    = (occ_o == OCC_MAX);
    assign at_zero   = (occ_o == '0);
    assign bad_alloc = alloc_i && !ret_i && at_max;
    assign bad_ret   = ret_i && !alloc_i && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_o <= '0;
        end else if (alloc_i && !ret_i && !at_max) begin
            occ_o <= occ_o + 1'b1;
        end else if (ret_i && !alloc_i && !at_zero) begin
            occ_o <= occ_o - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (bad_alloc || bad_ret) begin
            err_o <= 1'b1;
        end else if (err_clr_i) begin
            err_o <= 1'b0;
        end
    end

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_o <= OCC_MAX);
    assert_err_on_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !alloc_i && occ_o == '0) |=> (err_o && occ_o == '0));
    assert_pair_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && ret_i) |=> $stable(occ_o));
endmodule

// File: rtl/ort_accum.sv
module ort_accum #(
    parameter int CNT_W = 48,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (en_i) begin
            cnt_o <= cnt_o + CNT_W'(inc_i);
        end
    end

    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_o));
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/ort_ctrl.sv
module ort_ctrl
    import ort_pkg::*;
#(
    parameter int OCC_W   = 6,
    parameter int THR_RST = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [2:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic             count_en_o,
    output logic             frozen_o,
    output logic             cnt_clr_o,
    output logic             err_clr_o,
    output logic [OCC_W-1:0] thr_o
);
    ort_state_e state_q, state_d;
    logic       ctl_wr;

    assign ctl_wr = wr_i && (addr_i == A_CTRL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ctl_wr && wdata_i[CTL_FREEZE_BIT])  state_d = ST_FROZEN;
            ST_FROZEN: if (ctl_wr && !wdata_i[CTL_FREEZE_BIT]) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        count_en_o = 1'b0;
        frozen_o   = 1'b0;
        unique case (state_q)
            ST_RUN:    count_en_o = 1'b1;
            ST_FROZEN: frozen_o   = 1'b1;
        endcase
        cnt_clr_o = ctl_wr && wdata_i[CTL_CLR_BIT];
        err_clr_o = ctl_wr && wdata_i[CTL_ERRCLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_o <= OCC_W'(THR_RST);
        end else if (wr_i && addr_i == A_THR) begin
            thr_o <= wdata_i[OCC_W-1:0];
        end
    end

    assert_state_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(state_q));
    assert_freeze_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata_i[CTL_FREEZE_BIT]) |=> frozen_o);
endmodule

// File: rtl/ort_top.sv
module ort_top
    import ort_pkg::*;
#(
    parameter int MAX_REQ = 40,
    parameter int CNT_W   = 48,
    parameter int THR_PCT = 70
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_alloc_i,
    input  logic        req_ret_i,
    input  logic        cfg_wr_i,
    input  logic [2:0]  cfg_addr_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o
);
    localparam int OCC_W   = $clog2(MAX_REQ + 1);
    localparam int THR_RST = (MAX_REQ * THR_PCT) / 100;
    localparam int N_ACC   = 3;

    logic [OCC_W-1:0] occ, thr;
    logic             err, count_en, frozen, cnt_clr, err_clr;
    logic [OCC_W-1:0] inc_a [N_ACC];
    logic [CNT_W-1:0] cnt_a [N_ACC];

    ort_occ_tracker #(.MAX_REQ(MAX_REQ), .OCC_W(OCC_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .alloc_i(req_alloc_i), .ret_i(req_ret_i),
        .err_clr_i(err_clr), .occ_o(occ), .err_o(err)
    );

    ort_ctrl #(.OCC_W(OCC_W), .THR_RST(THR_RST)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .count_en_o(count_en), .frozen_o(frozen),
        .cnt_clr_o(cnt_clr), .err_clr_o(err_clr), .thr_o(thr)
    );

    assign inc_a[0] = occ;
    assign inc_a[1] = OCC_W'(occ != '0);
    assign inc_a[2] = OCC_W'(occ >= thr);

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        ort_accum #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .en_i(count_en), .clr_i(cnt_clr),
            .inc_i(inc_a[g]), .cnt_o(cnt_a[g])
        );
    end

    logic [63:0] sel_wide;
    logic [1:0]  sel_idx;

    always_comb begin
        sel_idx  = cfg_addr_i[2:1] - 2'd1;
        sel_wide = '0;
        if (cfg_addr_i[2:1] != 2'd0) sel_wide = 64'(cnt_a[sel_idx]);
        cfg_rdata_o = '0;
        unique case (cfg_addr_i)
            A_CTRL: begin
                cfg_rdata_o[CTL_FREEZE_BIT] = frozen;
                cfg_rdata_o[CTL_CLR_BIT]    = err;
                cfg_rdata_o[CTL_OCC_LSB +: OCC_W] = occ;
            end
            A_THR:                           cfg_rdata_o[OCC_W-1:0] = thr;
            A_SUM_LO, A_BUSY_LO, A_SAT_LO:   cfg_rdata_o = sel_wide[31:0];
            A_SUM_HI, A_BUSY_HI, A_SAT_HI:   cfg_rdata_o = sel_wide[63:32];
            default:                         cfg_rdata_o = '0;
        endcase
    end

    assert_sat_implies_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !cnt_clr && occ != '0 && occ >= thr) |=> (cnt_a[1] == $past(cnt_a[1]) + 1'b1));
endmodule

// File: tb/sim_ort_top.sv
module sim_ort_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc = 1'b0, ret = 1'b0, wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int     checks = 0, errors = 0;
    bit     done = 1'b0;
    int     m_occ = 0, m_thr = 28;
    bit     m_frozen = 1'b0, m_err = 1'b0;
    longint m_sum = 0, m_busy = 0, m_sat = 0;

    always #10 clk = ~clk;

    ort_top u0 (
        .clk(clk), .rst_n(rst_n), .req_alloc_i(alloc), .req_ret_i(ret),
        .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
    );

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // one clock with given inputs; model follows the requirements
    task automatic tick(input bit a, input bit r, input bit w, input logic [2:0] ad, input logic [31:0] d);
        alloc = a; ret = r; wr = w; addr = ad; wdata = d;
        if (!m_frozen) begin
            m_sum += m_occ;
            if (m_occ >= 1) m_busy++;
            if (m_occ >= m_thr) m_sat++;
        end
        @(posedge clk);
        if (w && ad == 3'd0) begin
            if (d[1]) begin m_sum = 0; m_busy = 0; m_sat = 0; end
            m_frozen = d[0];
            if (d[2]) m_err = 1'b0;
        end
        if (w && ad == 3'd1) m_thr = int'(d[5:0]);
        if (a && !r) begin
            if (m_occ == 40) m_err = 1'b1; else m_occ++;
        end
        if (r && !a) begin
            if (m_occ == 0) m_err = 1'b1; else m_occ--;
        end
        @(negedge clk);
        alloc = 1'b0; ret = 1'b0; wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 3'd0, 0);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] lo, hi;
        rd(3'd0, lo);
        check({tag, " R2 occupancy"}, lo[13:8], m_occ);
        check({tag, " R3 error flag"}, lo[1], m_err);
        check({tag, " R7 frozen"}, lo[0], m_frozen);
        rd(3'd1, lo);
        check({tag, " R6 threshold"}, lo[5:0], m_thr);
        rd(3'd2, lo); rd(3'd3, hi);
        check({tag, " R4 occ sum"}, {hi[15:0], lo}, m_sum);
        check({tag, " R9 sum hi zero-ext"}, hi[31:16], 0);
        rd(3'd4, lo); rd(3'd5, hi);
        check({tag, " R5 busy"}, {hi[15:0], lo}, m_busy);
        rd(3'd6, lo); rd(3'd7, hi);
        check({tag, " R6 saturated"}, {hi[15:0], lo}, m_sat);
    endtask

    task automatic t_reset;
        check_all("R1 reset");
        check("R1 threshold default", m_thr, 28);
    endtask

    task automatic t_inc_dec;
        for (int i = 0; i < 5; i++) tick(1, 0, 0, 3'd0, 0);
        check_all("R2 after allocs");
        tick(1, 1, 0, 3'd0, 0);
        tick(1, 1, 0, 3'd0, 0);
        check_all("R2 paired pulses");
        tick(0, 1, 0, 3'd0, 0);
        idle(3);
        check_all("R4 R5 mixed");
    endtask

    task automatic t_errors;
        while (m_occ > 0) tick(0, 1, 0, 3'd0, 0);
        tick(0, 1, 0, 3'd0, 0);
        check_all("R3 return at zero");
        tick(0, 0, 1, 3'd0, 32'h4);
        check_all("R3 error cleared");
        for (int i = 0; i < 41; i++) tick(1, 0, 0, 3'd0, 0);
        check_all("R3 allocate at max");
        tick(0, 0, 1, 3'd0, 32'h4);
        while (m_occ > 0) tick(0, 1, 0, 3'd0, 0);
        check_all("R3 drained");
    endtask

    task automatic t_threshold;
        tick(0, 0, 1, 3'd0, 32'h2);
        tick(0, 0, 1, 3'd1, 32'd3);
        for (int i = 0; i < 6; i++) tick(1, 0, 0, 3'd0, 0);
        idle(2);
        for (int i = 0; i < 4; i++) tick(0, 1, 0, 3'd0, 0);
        check_all("R6 threshold 3");
        tick(0, 0, 1, 3'd1, 32'd0);
        idle(3);
        check_all("R6 threshold 0");
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        tick(0, 0, 1, 3'd0, 32'h1);
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 3'd0, 0);
        check_all("R7 frozen hold");
        rd(3'd0, v);
        check("R7 frozen bit", v[0], 1);
        tick(0, 0, 1, 3'd0, 32'h0);
        idle(2);
        check_all("R7 resumed");
    endtask

    task automatic t_clear;
        tick(0, 0, 1, 3'd0, 32'h2);
        check_all("R8 cleared");
        idle(2);
        check_all("R8 after clear");
        tick(0, 0, 1, 3'd0, 32'h3);
        idle(2);
        check_all("R8 clear while freezing");
    endtask

    task automatic t_comb_read;
        logic [31:0] v;
        addr = 3'd1;
        #1;
        v = rdata;
        addr = 3'd0;
        #1;
        check("R10 same-cycle read", rdata[13:8], m_occ);
        check("R10 thr read", v[5:0], m_thr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inc_dec();
        t_errors();
        t_threshold();
        t_freeze();
        t_clear();
        t_comb_read();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule